// File: doc/BRIEF.md
# Five-Register Majority-Clocked Keystream Generator

This block generates a serial keystream from a 64-bit session key. The key is split directly across five linear feedback shift registers: four of 13 bits and one of 12 bits, so every key bit lands in exactly one register. On each step, one clocking bit is taken from every register and their five-way majority is computed. Only the registers whose clocking bit agrees with that majority shift. Because five is odd, the vote can never tie. A shifting register moves its contents one place toward its high end and places the XOR of its tap bits at position 1.

The user strobes a new key, which restarts the generator. Then the user holds the enable high for as long as keystream is wanted. The first 100 enabled cycles after a load are warm-up steps and produce no output. After the warm-up, every enabled cycle produces one keystream bit, which is the XOR of the last bit of each of the five registers. The enable acts as a stall: while it is low, nothing moves and the stream resumes exactly where it stopped.

Top module: `mjk_keystream`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous) and after reset until the first key load, ks_valid is 0 and all registers hold zero.
- R2: A key load places key bit (b + j) at position j+1 of a register. Bases are b = 0, 13, 26 and 39 for the four 13-bit registers and b = 52 for the 12-bit register. Position 1 is the input end.
- R3: On every step, the majority is 1 exactly when three or more of the five clocking bits are 1. The clocking bit is position 5 in the 13-bit registers and position 6 in the 12-bit register. Only registers whose clocking bit equals the majority shift, so at least three shift on every step.
- R4: A shifting 13-bit register moves position p to p+1 and loads position 1 with the XOR of positions 4, 6, 12 and 13, all taken before the shift.
- R5: A shifting 12-bit register moves position p to p+1 and loads position 1 with the XOR of positions 11 and 12, both taken before the shift.
- R6: In an enabled cycle after warm-up, the design asserts ks_valid on the following cycle. It also presents ks_bit, which is the XOR of the last position of all five registers before that cycle's step. In any other cycle, ks_valid is 0 on the following cycle.
- R7: After a key load, the first 100 enabled cycles are majority-clocked warm-up steps with ks_valid held at 0. The 101st enabled cycle produces the first valid bit.
- R8: A cycle with en low changes no register and produces no output. The bit sequence after a pause is the same as it would be without the pause.
- R9: key_load takes priority over en in the same cycle. It reloads all registers and restarts the warm-up at any point, including during the warm-up or while output is streaming. ks_valid is 0 on the cycle after a load.
- R10: Before the first key load, en has no effect: ks_valid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_load | input | 1 | Load strobe for the session key; restarts warm-up |
| key | input | 64 | Session key, sampled when key_load is high |
| en | input | 1 | Step enable; low stalls the generator |
| ks_bit | output | 1 | Keystream bit, meaningful when ks_valid is 1 |
| ks_valid | output | 1 | One-cycle flag marking a fresh keystream bit |

## Verification
Key loading and stepping can both be requested in the same cycle, and a load can arrive at any point of the warm-up or of the stream. The bench drives key_load and en together on purpose, reloads after a partial warm-up, and reloads in the middle of the output stream. It judges each case against a bench model that gives the load priority and restarts its 100-step count. Random enable gaps placed around these loads check that a stalled cycle neither steps the registers nor consumes part of the warm-up.

// File: rtl/mjk_pkg.sv
package mjk_pkg;
  localparam int NREG        = 5;
  localparam int KEY_W       = 64;
  localparam int WARM_CYCLES = 100;
  localparam int CNT_W       = $clog2(WARM_CYCLES + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_WARM, PH_RUN} phase_t;

  // register lengths: four long registers then one short one
  function automatic int reg_len(input int idx);
    return (idx == NREG - 1) ? 12 : 13;
  endfunction

  // first key bit that belongs to register idx
  function automatic int key_base(input int idx);
    int acc;
    acc = 0;
    for (int k = 0; k < idx; k++) acc += reg_len(k);
    return acc;
  endfunction

  // tap mask: bit (p-1) set for tap position p
  function automatic logic [31:0] tap_mask(input int idx);
    if (idx == NREG - 1) return (32'd1 << 10) | (32'd1 << 11);
    return (32'd1 << 3) | (32'd1 << 5) | (32'd1 << 11) | (32'd1 << 12);
  endfunction

  // clocking position, 1-based
  function automatic int clk_pos(input int idx);
    return (idx == NREG - 1) ? 6 : 5;
  endfunction

  // strict majority over NREG votes
  function automatic logic majority(input logic [NREG-1:0] v);
    int ones;
    ones = 0;
    for (int k = 0; k < NREG; k++) ones += int'(v[k]);
    return (ones > NREG / 2);
  endfunction
endpackage

// File: rtl/mjk_lfsr.sv
module mjk_lfsr #(
  parameter int          LEN    = 13,
  parameter logic [31:0] TAPS   = 32'h0000_1828,
  parameter int          CLKPOS = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [LEN-1:0] load_val,
  input  logic           step,
  output logic           clk_bit,
  output logic           out_bit
);
  // index p-1 holds position p; index 0 is the input end
  logic [LEN-1:0] state;
  logic           fb;

  assign fb      = ^(state & TAPS[LEN-1:0]);
  assign clk_bit = state[CLKPOS-1];
  assign out_bit = state[LEN-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= '0;
    else if (load) state <= load_val;
    else if (step) state <= {state[LEN-2:0], fb};
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(state)) else $error("hold");            // R8

  AST_SHIFT_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step) |=> state[LEN-1:1] == $past(state[LEN-2:0])) else $error("shift"); // R4

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> state == $past(load_val)) else $error("load");              // R2
endmodule

// File: rtl/mjk_vote.sv
module mjk_vote
  import mjk_pkg::*;
(
  input  logic [NREG-1:0] votes,
  output logic            maj,
  output logic [NREG-1:0] agree
);
  assign maj   = majority(votes);
  assign agree = ~(votes ^ {NREG{maj}});
endmodule

// File: rtl/mjk_seq.sv
module mjk_seq
  import mjk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic key_load,
  input  logic en,
  output logic advance,
  output logic emit
);
  phase_t           phase;
  logic [CNT_W-1:0] warm_cnt;

  assign advance = en && !key_load && (phase != PH_IDLE);
  assign emit    = advance && (phase == PH_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      warm_cnt <= '0;
    end else if (key_load) begin
      phase    <= PH_WARM;
      warm_cnt <= CNT_W'(WARM_CYCLES);
    end else if (advance && phase == PH_WARM) begin
      if (warm_cnt == CNT_W'(1)) phase <= PH_RUN;
      warm_cnt <= warm_cnt - CNT_W'(1);
    end
  end

  AST_WARM_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && phase == PH_WARM && !key_load) |=>
      (warm_cnt == $past(warm_cnt) - CNT_W'(1))) else $error("warm");   // R7

  AST_NO_EMIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !emit) else $error("idle emit");             // R10
endmodule

// File: rtl/mjk_keystream.sv
module mjk_keystream
  import mjk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_load,
  input  logic [KEY_W-1:0] key,
  input  logic             en,
  output logic             ks_bit,
  output logic             ks_valid
);
  logic [NREG-1:0] clk_bits;
  logic [NREG-1:0] out_bits;
  logic [NREG-1:0] agree;
  logic [NREG-1:0] step_vec;
  logic            maj;
  logic            advance;
  logic            emit;

  mjk_seq u_seq (
    .clk(clk), .rst_n(rst_n), .key_load(key_load), .en(en),
    .advance(advance), .emit(emit)
  );

  mjk_vote u_vote (.votes(clk_bits), .maj(maj), .agree(agree));

  assign step_vec = agree & {NREG{advance}};

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam int          LEN  = reg_len(g);
    localparam int          BASE = key_base(g);
    localparam logic [31:0] TAPS = tap_mask(g);
    localparam int          CPOS = clk_pos(g);
    mjk_lfsr #(.LEN(LEN), .TAPS(TAPS), .CLKPOS(CPOS)) u_lfsr (
      .clk(clk), .rst_n(rst_n), .load(key_load),
      .load_val(key[BASE +: LEN]), .step(step_vec[g]),
      .clk_bit(clk_bits[g]), .out_bit(out_bits[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ks_bit   <= 1'b0;
      ks_valid <= 1'b0;
    end else begin
      ks_valid <= emit;
      if (emit) ks_bit <= ^out_bits;
    end
  end

  AST_MIN_THREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> ($countones(step_vec) >= 3)) else $error("vote");       // R3

  AST_NO_STEP_WITHOUT_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (step_vec == '0)) else $error("en");                        // R8

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    key_load |=> !ks_valid) else $error("load prio");                   // R9

  AST_VALID_FROM_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ks_valid |-> $past(en)) else $error("valid src");                   // R6
endmodule

// File: tb/mjk_keystream_tb.sv
module mjk_keystream_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        key_load = 1'b0;
  logic [63:0] key = '0;
  logic        en = 1'b0;
  logic        ks_bit;
  logic        ks_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  mjk_keystream u_dut (
    .clk(clk), .rst_n(rst_n), .key_load(key_load), .key(key),
    .en(en), .ks_bit(ks_bit), .ks_valid(ks_valid)
  );

  // bench model: position p of register r stored at index len-p
  logic [12:0] m [5];
  bit          m_loaded;
  bit          m_run;
  int          m_warm;
  bit          e_valid;
  bit          e_bit;

  function automatic int blen(input int r);
    return (r == 4) ? 12 : 13;
  endfunction

  function automatic bit mpos(input int r, input int p);
    return m[r][blen(r) - p];
  endfunction

  task automatic model_load(input logic [63:0] k);
    int b;
    b = 0;
    for (int r = 0; r < 5; r++) begin
      m[r] = '0;
      for (int j = 0; j < blen(r); j++) m[r][blen(r) - 1 - j] = k[b + j];
      b += blen(r);
    end
    m_loaded = 1; m_run = 0; m_warm = 100;
  endtask

  task automatic model_step();
    int   ones;
    bit   mj;
    bit   fb;
    bit   cb [5];
    ones = 0;
    for (int r = 0; r < 5; r++) begin
      cb[r] = mpos(r, (r == 4) ? 6 : 5);
      ones += cb[r];
    end
    mj = (ones >= 3);
    for (int r = 0; r < 5; r++) begin
      if (cb[r] == mj) begin
        if (r == 4) fb = mpos(r, 11) ^ mpos(r, 12);
        else        fb = mpos(r, 4) ^ mpos(r, 6) ^ mpos(r, 12) ^ mpos(r, 13);
        m[r] = (m[r] >> 1);
        m[r][blen(r) - 1] = fb;
      end
    end
  endtask

  function automatic string vtag(input bit ld, input bit e);
    if (ld)        return "R9";
    if (!m_loaded) return "R10";
    if (!e)        return "R8";
    if (!m_run)    return "R7";
    return "R6";
  endfunction

  // one clock: drive, edge, update model, compare
  task automatic cyc(input bit ld, input logic [63:0] k, input bit e);
    string tag;
    bit    was_run;
    key_load = ld; key = k; en = e;
    @(posedge clk);
    #1;
    tag = vtag(ld, e);
    e_valid = 0;
    if (ld) model_load(k);
    else if (e && m_loaded) begin
      was_run = m_run;
      if (was_run) begin
        e_valid = 1;
        e_bit = 0;
        for (int r = 0; r < 5; r++) e_bit ^= mpos(r, blen(r));
      end else begin
        m_warm--;
        if (m_warm == 0) m_run = 1;
      end
      model_step();
    end
    n_chk++;
    if (ks_valid !== e_valid) begin
      n_bad++;
      $display("FAIL %s valid: actual %b expected %b", tag, ks_valid, e_valid);
    end
    if (e_valid) begin
      n_chk++;
      if (ks_bit !== e_bit) begin
        n_bad++;
        $display("FAIL R2/R3/R4/R5/R6 bit: actual %b expected %b", ks_bit, e_bit);
      end
    end
  endtask

  task automatic run_rand(input int n, input int en_pct);
    for (int i = 0; i < n; i++) cyc(1'b0, '0, ($urandom % 100) < en_pct);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] k;
    int          cnt;
    void'($urandom(32'd1357));
    for (int r = 0; r < 5; r++) m[r] = '0;
    m_loaded = 0; m_run = 0; m_warm = 0;
    #22;
    n_chk++;
    if (ks_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset valid: actual %b expected 0", ks_valid);
    end
    @(negedge clk); rst_n = 1'b1;

    // R10: enable before any key
    for (int i = 0; i < 6; i++) cyc(1'b0, '0, 1'b1);

    // R9: load together with enable
    k = {$urandom, $urandom};
    cyc(1'b1, k, 1'b1);
    // R7: count enabled cycles until first valid
    cnt = 0;
    for (int i = 0; i < 101; i++) begin
      cyc(1'b0, '0, 1'b1);
      cnt++;
      if (ks_valid) break;
    end
    n_chk++;
    if (cnt != 101) begin
      n_bad++;
      $display("FAIL R7 first valid after: actual %0d expected 101", cnt);
    end
    run_rand(60, 100);

    // R9: reload mid-stream, then mid-warm-up
    cyc(1'b1, {$urandom, $urandom}, 1'b0);
    run_rand(40, 80);
    cyc(1'b1, 64'hF0F0_1234_8001_AAAA, 1'b1);
    run_rand(200, 70);

    // R8: long stall keeps state
    for (int i = 0; i < 20; i++) cyc(1'b0, '0, 1'b0);
    run_rand(30, 100);

    // directed keys
    cyc(1'b1, 64'h0, 1'b0);                 run_rand(130, 100);
    cyc(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0); run_rand(130, 100);
    cyc(1'b1, 64'h8000_0000_0000_0001, 1'b0); run_rand(130, 100);

    // random keys with random gaps
    for (int t = 0; t < 25; t++) begin
      cyc(1'b1, {$urandom, $urandom}, ($urandom % 2) == 0);
      run_rand(220, 75);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule